// File: doc/BRIEF.md
# Dual-Format Audio Serial Receiver

This block receives stereo 24-bit audio from a serial link in which it acts only as a slave. It takes the bit clock, the channel-select clock and the serial data line as plain inputs. It oversamples them in a faster system clock domain through synchroniser chains. Each bit is taken at a rising edge of the bit clock. The left and right words are then delivered together on two parallel outputs with a single-cycle strobe.

A static mode input chooses between two framings. In the left-justified framing, the first data bit follows the channel-select change at once. In the I2S framing, the first data bit comes one bit slot later. A watchdog counts system cycles between bit-clock rising edges. When the bit clock stops, it raises a flag so that downstream mute logic can react.

Top module: `aud_serial_rx`

## Requirements
- R1: `fmt_lj` = 1 selects left-justified framing and `fmt_lj` = 0 selects I2S framing. The mode is applied at each channel-select transition.
- R2: In left-justified framing, the data bit sampled at the first bit-clock rising edge that sees a new channel-select level is the MSB (bit 23) of the new word.
- R3: In I2S framing, the bit sampled at that first rising edge is discarded, and the MSB is taken at the second rising edge after the transition.
- R4: Bits arrive MSB first. Successive rising edges fill bits 23, 22, … down to 0 of the word.
- R5: Channel-select low carries the left word and high carries the right word. A falling transition starts a left word and a rising transition starts a right word.
- R6: `word_valid` pulses for exactly one system cycle when bit 0 of the right word has been sampled. At that moment `left_out` and `right_out` present the pair together and hold their values until the next pulse.
- R7: Bit-clock edges after the 24th bit of a channel are ignored until the next channel-select transition.
- R8: A word cut short by a channel-select transition keeps the bits received so far, and its remaining low bits are zero. A short right word is delivered, with a pulse, at that next transition.
- R9: `bclk_stopped` rises once 256 consecutive system cycles pass without a bit-clock rising edge. It falls in the cycle after the next detected rising edge.
- R10: After reset, `word_valid`, `left_out`, `right_out` and `bclk_stopped` are all zero. Bits sampled before the first channel-select transition after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrclk_in | input | 1 | Channel-select clock, low = left (asynchronous) |
| sdata_in | input | 1 | Serial data line (asynchronous) |
| fmt_lj | input | 1 | Framing select: 1 left-justified, 0 I2S |
| left_out | output | 24 | Received left word |
| right_out | output | 24 | Received right word |
| word_valid | output | 1 | One-cycle strobe when a new pair is presented |
| bclk_stopped | output | 1 | Bit clock has been idle for 256 cycles |

## Verification
An input level reaches the edge detector after the two synchroniser stages. A word pair therefore appears on the outputs three system cycles after the bit-clock rising edge that carried the last right bit. The stopped flag clears one cycle after that detector fires. The scoreboard does not predict a cycle for each pair. It queues the expected pairs in order and compares them on the falling clock edge of every strobe. A final check confirms that no expected pair remains unmatched. The flag checks sit well clear of the 256-cycle threshold, at 200 and 300 idle cycles and six cycles after a restart edge, so that the synchroniser delay cannot move them across it.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    localparam int unsigned SAMPLE_W = 24;
    localparam int unsigned CNT_W    = $clog2(SAMPLE_W + 1);

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    // Return a copy of w with bit position pos replaced by b.
    function automatic sample_t put_bit(sample_t w, int pos, logic b);
        sample_t r;
        r = w;
        for (int i = 0; i < int'(SAMPLE_W); i++) begin
            if (i == pos) r[i] = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] d_out
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], d_in[b]};
        end
        assign d_out[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic prev_q;
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level;
    end
    assign rise = level & ~prev_q;
endmodule

// File: rtl/aud_rx_bclk_watch.sv
module aud_rx_bclk_watch #(
    parameter int unsigned IDLE_LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic stopped
);
    localparam int unsigned IW = $clog2(IDLE_LIMIT + 1);
    localparam logic [IW-1:0] LIM = IW'(IDLE_LIMIT);

    logic [IW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst)               idle_q <= '0;
        else if (rise)         idle_q <= '0;
        else if (idle_q != LIM) idle_q <= idle_q + IW'(1);
    end

    assign stopped = (idle_q == LIM);
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
    import aud_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_e  fmt,
    input  logic  rise,
    input  logic  lr,
    input  logic  dat,
    output pair_t pair,
    output logic  valid
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

    logic             lr_last_q, lr_last_n;
    logic             started_q, started_n;
    chan_e            chan_q, chan_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    sample_t          acc_q, acc_n;
    sample_t          hold_q, hold_n;
    pair_t            pair_q, pair_n;
    logic             emit;

    always_comb begin
        lr_last_n = lr_last_q;
        started_n = started_q;
        chan_n    = chan_q;
        cnt_n     = cnt_q;
        acc_n     = acc_q;
        hold_n    = hold_q;
        pair_n    = pair_q;
        emit      = 1'b0;
        if (rise) begin
            lr_last_n = lr;
            if (lr != lr_last_q) begin
                // Channel boundary: close the running word.
                if (started_q) begin
                    if (chan_q == CH_LEFT) begin
                        hold_n = acc_q;
                    end else if (cnt_q < CNT_FULL) begin
                        emit   = 1'b1;
                        pair_n = '{left: hold_q, right: acc_q};
                    end
                end
                started_n = 1'b1;
                chan_n    = lr ? CH_RIGHT : CH_LEFT;
                acc_n     = '0;
                if (fmt == FMT_LJ) begin
                    acc_n = put_bit('0, int'(SAMPLE_W) - 1, dat);
                    cnt_n = CNT_W'(1);
                end else begin
                    cnt_n = '0;
                end
            end else if (started_q && cnt_q < CNT_FULL) begin
                acc_n = put_bit(acc_q, int'(SAMPLE_W) - 1 - int'(cnt_q), dat);
                cnt_n = cnt_q + CNT_W'(1);
                if (chan_q == CH_RIGHT && cnt_q == CNT_LAST) begin
                    emit   = 1'b1;
                    pair_n = '{left: hold_q, right: acc_n};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_last_q <= 1'b1;
            started_q <= 1'b0;
            chan_q    <= CH_LEFT;
            cnt_q     <= '0;
            acc_q     <= '0;
            hold_q    <= '0;
            pair_q    <= '0;
            valid     <= 1'b0;
        end else begin
            lr_last_q <= lr_last_n;
            started_q <= started_n;
            chan_q    <= chan_n;
            cnt_q     <= cnt_n;
            acc_q     <= acc_n;
            hold_q    <= hold_n;
            pair_q    <= pair_n;
            valid     <= emit;
        end
    end

    assign pair = pair_q;
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IDLE_LIMIT  = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    input  logic                fmt_lj,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                word_valid,
    output logic                bclk_stopped
);
    logic [2:0] raw_in, sync_out;
    logic       bclk_s, lr_s, dat_s, bclk_rise;
    pair_t      pair;
    fmt_e       fmt;

    assign raw_in = {bclk_in, lrclk_in, sdata_in};
    assign {bclk_s, lr_s, dat_s} = sync_out;
    assign fmt = fmt_lj ? FMT_LJ : FMT_I2S;

    aud_rx_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(raw_in), .d_out(sync_out)
    );

    aud_rx_edge u_edge (
        .clk(clk), .rst(rst), .level(bclk_s), .rise(bclk_rise)
    );

    aud_rx_frame u_frame (
        .clk(clk), .rst(rst), .fmt(fmt), .rise(bclk_rise),
        .lr(lr_s), .dat(dat_s), .pair(pair), .valid(word_valid)
    );

    aud_rx_bclk_watch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
        .clk(clk), .rst(rst), .rise(bclk_rise), .stopped(bclk_stopped)
    );

    assign left_out  = pair.left;
    assign right_out = pair.right;
endmodule

// File: rtl/aud_rx_checker.sv
module aud_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic        rise,
    input logic        valid,
    input logic        stopped,
    input logic [23:0] left,
    input logic [23:0] right
);
    // R6: strobe lasts a single cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6: a strobe only follows a detected bit-clock edge
    p_valid_after_edge_r6: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(rise));

    // R6: words hold between strobes
    p_words_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ($stable(left) && $stable(right)));

    // R9: an edge clears the stopped flag
    p_stop_clear_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !stopped);

    // R9: without an edge the flag stays up
    p_stop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stopped && !rise) |=> stopped);
endmodule

bind aud_serial_rx aud_rx_checker u_chk (
    .clk(clk), .rst(rst), .rise(bclk_rise), .valid(word_valid),
    .stopped(bclk_stopped), .left(left_out), .right(right_out)
);

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0, fmt_lj = 1'b1;
    logic [23:0] left_out, right_out;
    logic        word_valid, bclk_stopped;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    aud_serial_rx u_dut (
        .clk(clk), .rst(rst), .bclk_in(bclk), .lrclk_in(lrclk),
        .sdata_in(sdata), .fmt_lj(fmt_lj), .left_out(left_out),
        .right_out(right_out), .word_valid(word_valid),
        .bclk_stopped(bclk_stopped)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic slot(input logic lr, input logic d);
        bclk  = 1'b0;
        lrclk = lr;
        sdata = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [23:0] top_mask(input int n);
        return ~(24'hFFFFFF >> n);
    endfunction

    // Driver: queues the expected pair, then sends one stereo frame.
    task automatic frame(input logic lj, input logic [23:0] l, input logic [23:0] r,
                         input int nl, input int nr, input int extra, input string tag);
        exp_t e;
        e.l = l & top_mask(nl);
        e.r = r & top_mask(nr);
        e.tag = tag;
        exp_q.push_back(e);
        fmt_lj = lj;
        for (int ch = 0; ch < 2; ch++) begin
            logic [23:0] w;
            int n;
            w = (ch == 0) ? l : r;
            n = (ch == 0) ? nl : nr;
            if (!lj) slot(ch[0], 1'b1);
            for (int i = 0; i < n; i++) slot(ch[0], w[23-i]);
            for (int k = 0; k < extra; k++) slot(ch[0], ~k[0]);
        end
    endtask

    // Monitor: pops expected pairs as the design strobes.
    always @(negedge clk) begin
        if (!rst && word_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R6: actual=unexpected strobe expected=none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " left"},  left_out,  e.l);
                check({e.tag, " right"}, right_out, e.r);
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 valid after reset",   {23'd0, word_valid},   24'd0);
        check("R10 left after reset",    left_out,              24'd0);
        check("R10 right after reset",   right_out,             24'd0);
        check("R10 stopped after reset", {23'd0, bclk_stopped}, 24'd0);

        // R10: bits before the first transition are ignored
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b1);

        // R1 R2 R4 R5 R6: left-justified, full words
        frame(1'b1, 24'hA5C3F0, 24'h0F1E2D, 24, 24, 0, "R2 R4 R5 lj full");
        // R1 R3: I2S full words
        frame(1'b0, 24'h123456, 24'hFEDCBA, 24, 24, 0, "R3 i2s full");
        // R7: extra edges after the 24th bit, both framings
        frame(1'b1, 24'h800001, 24'h7FFFFE, 24, 24, 5, "R7 lj extra");
        frame(1'b0, 24'hC0FFEE, 24'hBADF00, 24, 24, 3, "R7 i2s extra");
        // R8: short left word, zero padded
        frame(1'b1, 24'hFFFFFF, 24'h5A5A5A, 20, 24, 0, "R8 lj short left");
        // R8: short right word, delivered at the next transition
        frame(1'b0, 24'h00FF00, 24'hFFFFFF, 24, 16, 0, "R8 i2s short right");
        frame(1'b1, 24'h3C3C3C, 24'hC3C3C3, 24, 24, 2, "R1 lj after i2s");

        // R9: bit-clock watchdog
        bclk = 1'b0;
        repeat (200) @(negedge clk);
        check("R9 not yet stopped", {23'd0, bclk_stopped}, 24'd0);
        repeat (100) @(negedge clk);
        check("R9 stopped", {23'd0, bclk_stopped}, 24'd1);
        bclk = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 cleared by edge", {23'd0, bclk_stopped}, 24'd0);

        repeat (10) @(negedge clk);
        check("R6 all pairs delivered", 24'(exp_q.size()), 24'd0);
        finish_run();
    end
endmodule